// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a two-wire bus master whose only job is to find out when a slave memory has finished a self-timed write. After a request it sends a Start condition and a write-type control byte: the fixed device code, the three chip-select bits, and a zero direction bit. It then reads the acknowledge bit. A slave that is still busy does not acknowledge. On such a miss the poller closes the bus with a Stop, waits the bus-free time, and tries again. On the first acknowledge it closes the bus and gives a one-cycle done pulse, so the next read or write command can go ahead. An optional attempt limit ends a hopeless poll with a one-cycle fail pulse.

The block drives both bus lines as open-drain enables: a high enable pulls the line low, and a low enable releases it to its pull-up. SCL timing comes from the system clock. The low phase lasts `t_low` cycles and the high phase lasts `t_high` cycles. The Start hold time equals the high phase, and the bus-free gap equals the low phase. The poller does not issue the data transfer that follows, does not support clock stretching, and does not arbitrate with other masters.

The controller has eight states, each with a fixed open-drain output pattern:

- IDLE: both lines released. A request moves it to START.
- START: SDA pulled low while SCL is high.
- BIT_LO: SCL low; SDA carries the current bit.
- BIT_HI: SCL released.

The bit loop runs BIT_LO → BIT_HI → BIT_LO. After the ninth BIT_HI it moves to STOP_LO, with both lines low. STOP_HI then releases SCL, and FREE releases both lines. When FREE expires, it returns to START for a retry. After an acknowledge, or when the limit is reached, it goes instead to REPORT: a one-cycle outcome state, followed by IDLE.

Top module: `pollm_ack_poller`

## Requirements
- R1: After reset, and whenever idle, `scl_oe` and `sda_oe` are 0, `busy`, `done` and `fail` are 0, and `attempts` is 0 after reset.
- R2: Each attempt is a Start followed by the byte 1,0,1,0,cs[2],cs[1],cs[0],0, sent MSB first on the rising SCL edges. `cs` is `chip_sel` as captured at the request. SDA is released during the ninth SCL pulse.
- R3: With SCL high, SDA changes only to form a Start (SDA falls) or a Stop (SDA rises). An attempt contains exactly one of each.
- R4: If SDA is low at the end of the ninth SCL high phase, the poller finishes the Stop and the bus-free gap. It then pulses `done` for one cycle, with `attempts` equal to the number of attempts made.
- R5: If SDA is high at that point, the poller issues a Stop, waits the bus-free gap, and starts a new attempt. `attempts` counts each finished attempt.
- R6: Every SCL low phase lasts max(`t_low`,1) cycles. Every SCL high phase inside a byte lasts max(`t_high`,1) cycles. The Start hold (SDA low to SCL low) is max(`t_high`,1) cycles, and the Stop-to-Start gap is max(`t_low`,1) cycles.
- R7: With `max_tries` nonzero, after that many unacknowledged attempts the poller pulses `fail` instead of retrying. With `max_tries` = 0 it retries without limit.
- R8: While `busy` is high, `poll_req`, `chip_sel`, `max_tries`, `t_low` and `t_high` have no effect.
- R9: Let N be the number of attempts, Lo = max(`t_low`,1) and Hi = max(`t_high`,1). The outcome pulse is high in the cycle that follows clock edge number 11·N·(Lo+Hi) after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_req | input | 1 | Starts polling when idle |
| chip_sel | input | 3 | Chip-select bits for the control byte |
| max_tries | input | AW | Attempt limit, 0 = unlimited |
| t_low | input | TW | SCL low phase and bus-free gap, in cycles |
| t_high | input | TW | SCL high phase and Start hold, in cycles |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle pulse: slave acknowledged |
| fail | output | 1 | One-cycle pulse: attempt limit reached |
| attempts | output | AW | Attempts finished in the current or last poll |

## Verification
Every result has a due cycle that follows from R9. The request is raised just after a falling clock edge, and the bench records the number of falling edges seen so far. The outcome pulse is due exactly 1 + 11·N·(Lo+Hi) falling edges later, and the scoreboard compares that due cycle, the outcome kind and `attempts` against the pulse as it appears.

A bus monitor samples both lines on every falling clock edge. It measures each phase length, counts Starts and Stops, and decodes each control byte. These per-attempt counts are compared once the outcome has been consumed. The bus-model slave pulls SDA low one sample after the eighth SCL fall and releases it after the ninth fall, so its acknowledge is settled well before the poller samples it.

// File: rtl/pollm_pkg.sv
package pollm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_FREE,
        ST_REPORT
    } poll_state_e;

    localparam int unsigned FRAME_BITS = 9;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1);
    localparam logic [3:0]  DEV_CODE   = 4'b1010;

endpackage

// File: rtl/pollm_timer.sv
module pollm_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pollm_tries.sv
module pollm_tries #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bump,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_limit
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count    = cnt_q;
    assign at_limit = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/pollm_ack_poller.sv
module pollm_ack_poller
    import pollm_pkg::*;
#(
    parameter int unsigned TW = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_req,
    input  logic [2:0]    chip_sel,
    input  logic [AW-1:0] max_tries,
    input  logic [TW-1:0] t_low,
    input  logic [TW-1:0] t_high,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] attempts
);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(FRAME_BITS - 1);

    poll_state_e state_q, state_d;

    logic [2:0]       cs_q;
    logic [AW-1:0]    lim_q;
    logic [TW-1:0]    lo_q, hi_q;
    logic [IDX_W-1:0] idx_q;
    logic             acked_q;
    logic             expired;
    logic             at_limit;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             accept;
    logic             ack_slot;
    logic [7:0]       ctrl_byte;
    logic             bit_drive;

    assign accept    = (state_q == ST_IDLE) && poll_req;
    assign ack_slot  = (state_q == ST_BIT_HI) && expired && (idx_q == ACK_IDX);
    assign ctrl_byte = {DEV_CODE, cs_q, 1'b0};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (poll_req) state_d = ST_START;
            ST_START:   if (expired)  state_d = ST_BIT_LO;
            ST_BIT_LO:  if (expired)  state_d = ST_BIT_HI;
            ST_BIT_HI:  if (expired)  state_d = (idx_q == ACK_IDX) ? ST_STOP_LO : ST_BIT_LO;
            ST_STOP_LO: if (expired)  state_d = ST_STOP_HI;
            ST_STOP_HI: if (expired)  state_d = ST_FREE;
            ST_FREE:    if (expired)  state_d = (acked_q || at_limit) ? ST_REPORT : ST_START;
            ST_REPORT:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered
    always_comb begin
        unique case (state_d)
            ST_START, ST_BIT_HI, ST_STOP_HI: tmr_val = (state_q == ST_IDLE) ? t_high : hi_q;
            ST_BIT_LO, ST_STOP_LO, ST_FREE:  tmr_val = lo_q;
            default:                         tmr_val = TW'(1);
        endcase
    end

    assign tmr_load = (state_d != state_q);

    // State register and per-poll registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= '0;
            lim_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            idx_q   <= '0;
            acked_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cs_q    <= chip_sel;
                lim_q   <= max_tries;
                lo_q    <= t_low;
                hi_q    <= t_high;
                acked_q <= 1'b0;
            end
            if (state_q == ST_START) begin
                idx_q <= '0;
            end else if (state_q == ST_BIT_HI && expired) begin
                idx_q <= idx_q + 1'b1;
            end
            if (ack_slot) begin
                acked_q <= ~sda_i;
            end
        end
    end

    // Bit to drive: control byte MSB first, then released for acknowledge
    always_comb begin
        bit_drive = 1'b0;
        if (idx_q < ACK_IDX) begin
            bit_drive = ~ctrl_byte[3'(7 - int'(idx_q))];
        end
    end

    // Moore outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        done   = 1'b0;
        fail   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FREE: ;
            ST_START:   sda_oe = 1'b1;
            ST_BIT_LO:  begin scl_oe = 1'b1; sda_oe = bit_drive; end
            ST_BIT_HI:  sda_oe = bit_drive;
            ST_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_STOP_HI: sda_oe = 1'b1;
            ST_REPORT:  begin done = acked_q; fail = ~acked_q; end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    pollm_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    pollm_tries #(.W(AW)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bump     (ack_slot),
        .limit    (lim_q),
        .count    (attempts),
        .at_limit (at_limit)
    );
endmodule

// File: rtl/pollm_checker.sv
module pollm_checker #(
    parameter int unsigned TW = 8,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] attempts,
    input logic [AW-1:0] lim_q,
    input logic [TW-1:0] lo_q
);
    logic [TW:0] lo_run;
    logic [TW:0] lo_eff;

    assign lo_eff = (lo_q == '0) ? (TW+1)'(1) : {1'b0, lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lo_run <= '0;
        else if (scl_oe) lo_run <= lo_run + 1'b1;
        else             lo_run <= '0;
    end

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    assert_scl_low_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> (lo_run == lo_eff));

    assert_single_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_end_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || fail));

    assert_try_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lim_q != '0) |-> (attempts <= lim_q));

    assert_stop_in_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe && !$past(scl_oe)) |-> busy);

    assert_done_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (attempts != '0));
endmodule

bind pollm_ack_poller pollm_checker #(.TW(TW), .AW(AW)) u_pollm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .attempts (attempts),
    .lim_q    (lim_q),
    .lo_q     (lo_q)
);

// File: tb/tb_pollm_ack_poller.sv
module tb_pollm_ack_poller;
    localparam int TW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          poll_req;
    logic [2:0]    chip_sel;
    logic [AW-1:0] max_tries;
    logic [TW-1:0] t_low, t_high;
    logic          scl_oe, sda_oe, busy, done, fail;
    logic [AW-1:0] attempts;
    logic          slave_pull;
    wire           sda_bus = ~sda_oe & ~slave_pull;
    wire           scl_bus = ~scl_oe;

    always #2.5 clk = ~clk;

    pollm_ack_poller #(.TW(TW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .chip_sel(chip_sel),
        .max_tries(max_tries), .t_low(t_low), .t_high(t_high), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail),
        .attempts(attempts)
    );

    typedef struct {int due; bit ok; int tries;} exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0, ncyc = 0;
    logic [2:0] sl_cs;
    int sl_nack;
    logic [7:0] exp_byte;
    int cur_lo, cur_hi;
    int starts, stops, bytes, bad_bytes, lo_bad, gap_bad, hold_bad;
    int lo_run, start_cyc, stop_cyc, bitcnt;
    bit saw_stop, hold_pending, in_frame, prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] shreg;

    task automatic check(input bit c, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: scoreboard pop plus bus-model slave, sampled on falling clock edges
    always @(negedge clk) begin
        bit scl, sda;
        exp_t e;
        ncyc = ncyc + 1;
        if (rst_n && (done || fail)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4", "outcome with nothing expected", 1, 0);
            end else begin
                e = sb.pop_front();
                check(ncyc == e.due, "R9", "outcome cycle", ncyc, e.due);
                check(done == e.ok, e.ok ? "R4" : "R7", "done vs fail", int'(done), int'(e.ok));
                check(int'(attempts) == e.tries, "R5", "attempts", int'(attempts), e.tries);
            end
        end
        scl = scl_bus;
        sda = sda_bus;
        if (scl && prev_scl && prev_sda && !sda) begin
            starts++;
            if (saw_stop && (ncyc - stop_cyc) != cur_lo) gap_bad++;
            start_cyc = ncyc; hold_pending = 1'b1;
            bitcnt = 0; in_frame = 1'b1;
        end else if (scl && prev_scl && !prev_sda && sda) begin
            stops++; in_frame = 1'b0; stop_cyc = ncyc; saw_stop = 1'b1;
        end
        if (scl && !prev_scl) begin
            if (lo_run != 0 && lo_run != cur_lo) lo_bad++;
            lo_run = 0;
            if (in_frame) begin
                if (bitcnt < 8) shreg = {shreg[6:0], sda};
                bitcnt++;
            end
        end
        if (!scl) lo_run++;
        if (!scl && prev_scl && in_frame) begin
            if (hold_pending) begin
                if ((ncyc - start_cyc) != cur_hi) hold_bad++;
                hold_pending = 1'b0;
            end
            if (bitcnt == 8) begin
                bytes++;
                if (shreg != exp_byte) bad_bytes++;
                if (shreg == {4'b1010, sl_cs, 1'b0}) begin
                    if (sl_nack > 0) sl_nack--;
                    else slave_pull = 1'b1;
                end
            end
            if (bitcnt == 9) slave_pull = 1'b0;
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic run_poll(input logic [2:0] cs, input logic [2:0] scs, input int nack,
                            input int lim, input int lo, input int hi, input bit poke);
        int n, lo_e, hi_e;
        bit ok;
        lo_e = (lo == 0) ? 1 : lo;
        hi_e = (hi == 0) ? 1 : hi;
        if (cs != scs) begin n = lim; ok = 1'b0; end
        else if (lim != 0 && nack >= lim) begin n = lim; ok = 1'b0; end
        else begin n = nack + 1; ok = 1'b1; end
        @(negedge clk); #1;
        chip_sel = cs; max_tries = AW'(lim); t_low = TW'(lo); t_high = TW'(hi);
        sl_cs = scs; sl_nack = nack; exp_byte = {4'b1010, cs, 1'b0};
        cur_lo = lo_e; cur_hi = hi_e;
        starts = 0; stops = 0; bytes = 0; bad_bytes = 0;
        lo_bad = 0; gap_bad = 0; hold_bad = 0; saw_stop = 1'b0;
        poll_req = 1'b1;
        sb.push_back('{ncyc + 1 + n * 11 * (lo_e + hi_e), ok, n});
        @(negedge clk); #1;
        poll_req = 1'b0;
        if (poke) begin
            // R8: new request and settings while busy must change nothing
            repeat (20) @(negedge clk);
            #1;
            poll_req = 1'b1; chip_sel = ~cs; t_low = TW'(lo + 5); max_tries = AW'(1);
            @(negedge clk); #1;
            poll_req = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk); #1;
        check(!busy && !scl_oe && !sda_oe, "R1", "released after poll", int'({busy, scl_oe, sda_oe}), 0);
        check(bytes == n, "R2", "control bytes sent", bytes, n);
        check(bad_bytes == 0, poke ? "R8" : "R2", "wrong control bytes", bad_bytes, 0);
        check(starts == n && stops == n, "R3", "start+stop count", starts + stops, 2 * n);
        check(lo_bad == 0, "R6", "SCL low width errors", lo_bad, 0);
        check(hold_bad == 0 && gap_bad == 0, "R6", "start hold / bus-free errors", hold_bad + gap_bad, 0);
    endtask

    initial begin
        rst_n = 1'b0; poll_req = 1'b0; chip_sel = '0; max_tries = '0;
        t_low = 8'd2; t_high = 8'd1; slave_pull = 1'b0; sl_cs = '0; sl_nack = 0;
        cur_lo = 1; cur_hi = 1; exp_byte = '0;
        repeat (4) @(negedge clk);
        check(!scl_oe && !sda_oe, "R1", "lines in reset", int'({scl_oe, sda_oe}), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fail, "R1", "flags after reset", int'({busy, done, fail}), 0);
        check(attempts == '0, "R1", "attempts after reset", int'(attempts), 0);
        check(!scl_oe && !sda_oe, "R1", "lines idle", int'({scl_oe, sda_oe}), 0);

        run_poll(3'b101, 3'b101, 0, 4, 3, 2, 1'b0);  // R4 immediate acknowledge
        run_poll(3'b010, 3'b010, 3, 8, 2, 1, 1'b0);  // R5 three misses then ack
        run_poll(3'b001, 3'b110, 0, 3, 1, 1, 1'b0);  // R7 wrong select, limit hit
        run_poll(3'b111, 3'b111, 5, 0, 1, 2, 1'b0);  // R7 unlimited retries
        run_poll(3'b000, 3'b000, 2, 2, 2, 2, 1'b0);  // R7 limit boundary
        run_poll(3'b011, 3'b011, 1, 0, 4, 3, 1'b1);  // R8 poke while busy
        run_poll(3'b100, 3'b100, 1, 5, 0, 0, 1'b0);  // R6 zero phases count as one

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (ncyc >= 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", ncyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule